// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

The block is a synchronous binary up-counter built from identical narrow slices (4 bits by default). Each slice has a direct clear, a synchronous parallel load and two count enables. One enable, the parallel enable, only gates counting. The other, the trickle enable, gates counting and is also fed forward into the slice's carry output. The carry output is high while the trickle enable is high and the slice sits at its all-ones value.

The top level chains a parameterised number of slices with no added gating. The carry of each slice drives the trickle enable of the next. Clock, clear, load and the parallel enable are common to every slice. The chain therefore behaves as one wide counter in which every bit changes on the same rising edge. Its carry output can enable a further stage outside the block. Priority inside each slice is clear first, then load, then count, and otherwise hold.

Top module: `cnt_chain`

## Requirements
- R1: Driving `clr_n` low forces `count_out` to zero at once, without waiting for a clock edge, and the value stays zero while `clr_n` is low.
- R2: With `clr_n` high and `load_n` low at a rising edge, `count_out` takes the value of `data_in` after that edge, whatever the levels of `en_par` and `en_trk`.
- R3: With `clr_n` and `load_n` high and both `en_par` and `en_trk` high at a rising edge, `count_out` increases by exactly one after that edge.
- R4: With `clr_n` and `load_n` high and either enable low at a rising edge, `count_out` keeps its value.
- R5: A single slice that counts from its all-ones value (15 when 4 bits wide) returns to 0.
- R6: A slice's carry equals its trickle enable ANDed with its value being all ones. The carry is combinational, so it falls in the same cycle that the trickle enable falls.
- R7: The chain counts as one binary counter of `N_SLICES*SLICE_W` bits. A count carries into the next slice on the same edge that a lower slice wraps, and the whole counter wraps from all ones to zero.
- R8: `carry_out` is high exactly when `en_trk` is high and `count_out` is all ones.
- R9: Only the enable levels present at a rising edge matter. Pulses on `en_par` or `en_trk` that start and end between edges have no effect on `count_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by every slice |
| clr_n | input | 1 | Active-low asynchronous clear |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_par | input | 1 | Parallel count enable, common to all slices |
| en_trk | input | 1 | Trickle enable of the lowest slice |
| data_in | input | N_SLICES*SLICE_W | Preset value for the load |
| count_out | output | N_SLICES*SLICE_W | Counter value |
| carry_out | output | 1 | Carry of the top slice, used for cascading |

## Verification
The clocked properties are switched off while `clr_n` is low. They assume that a clear is held across at least one rising edge, so that no edge-to-edge relation spans a clear that came and went between two edges. The stimulus always holds a clear over one edge, while the bench still checks, between edges, that the outputs drop to zero at once. Inputs change only a little after an edge, so every edge samples settled enables, load and data. The enable pulses used for R9 begin and end inside one clock period.

// File: rtl/cnt_pkg.sv
`timescale 1ns/1ps
package cnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_COUNT = 2'd2
  } cnt_mode_e;
endpackage

// File: rtl/cnt_slice_ctrl.sv
`timescale 1ns/1ps
module cnt_slice_ctrl
  import cnt_pkg::*;
(
  input  logic      load_n,
  input  logic      en_p,
  input  logic      en_t,
  output cnt_mode_e mode
);
  // Load wins over both enables; counting needs both enables.
  always_comb begin
    if (!load_n)            mode = MODE_LOAD;
    else if (en_p && en_t)  mode = MODE_COUNT;
    else                    mode = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_slice_reg.sv
`timescale 1ns/1ps
module cnt_slice_reg
  import cnt_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic               clk,
  input  logic               clr_n,
  input  cnt_mode_e          mode,
  input  logic [SLICE_W-1:0] d,
  output logic [SLICE_W-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else begin
      case (mode)
        MODE_LOAD:  q <= d;
        MODE_COUNT: q <= q + SLICE_W'(1);
        default:    q <= q;
      endcase
    end
  end

  // R1: while clear is low the register reads zero
  always @(negedge clk) begin
    if (!clr_n) begin
      assert_clear_R1: assert (q == '0)
        else $error("clear did not force zero");
    end
  end
endmodule

// File: rtl/cnt_slice.sv
`timescale 1ns/1ps
module cnt_slice
  import cnt_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               load_n,
  input  logic               en_p,
  input  logic               en_t,
  input  logic [SLICE_W-1:0] d,
  output logic [SLICE_W-1:0] q,
  output logic               co
);
  localparam logic [SLICE_W-1:0] TERM = '1;

  cnt_mode_e mode;

  cnt_slice_ctrl u_ctrl (
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .mode   (mode)
  );

  cnt_slice_reg #(.SLICE_W(SLICE_W)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .mode  (mode),
    .d     (d),
    .q     (q)
  );

  // Trickle enable fed forward into the carry.
  assign co = en_t && (q == TERM);

  assert_load_R2: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(d))
    else $error("load did not copy data");

  assert_count_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t) |=> q == $past(q) + SLICE_W'(1))
    else $error("count did not advance by one");

  assert_hold_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q))
    else $error("value changed without enable");

  assert_carry_gate_R6: assert property (@(posedge clk) disable iff (!clr_n)
    co |-> en_t)
    else $error("carry high with trickle enable low");
endmodule

// File: rtl/cnt_chain.sv
`timescale 1ns/1ps
module cnt_chain #(
  parameter int N_SLICES = 4,
  parameter int SLICE_W  = 4
) (
  input  logic                          clk,
  input  logic                          clr_n,
  input  logic                          load_n,
  input  logic                          en_par,
  input  logic                          en_trk,
  input  logic [N_SLICES*SLICE_W-1:0]   data_in,
  output logic [N_SLICES*SLICE_W-1:0]   count_out,
  output logic                          carry_out
);
  localparam int W = N_SLICES * SLICE_W;

  logic [N_SLICES:0] trk;

  assign trk[0] = en_trk;

  for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
    cnt_slice #(.SLICE_W(SLICE_W)) u_slice (
      .clk    (clk),
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_p   (en_par),
      .en_t   (trk[i]),
      .d      (data_in[i*SLICE_W +: SLICE_W]),
      .q      (count_out[i*SLICE_W +: SLICE_W]),
      .co     (trk[i+1])
    );
  end

  assign carry_out = trk[N_SLICES];

  assert_chain_count_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk) |=> count_out == $past(count_out) + W'(1))
    else $error("chain did not advance as one counter");

  assert_chain_carry_R8: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> (en_trk && (count_out == {W{1'b1}})))
    else $error("chain carry high away from terminal count");
endmodule

// File: tb/cnt_chain_tb.sv
`timescale 1ns/1ps
module cnt_chain_tb;
  logic        clk    = 1'b0;
  logic        clr_n  = 1'b0;
  logic        load_n = 1'b1;
  logic        en_par = 1'b0;
  logic        en_trk = 1'b0;
  logic [15:0] din    = '0;
  logic [15:0] q16;
  logic [3:0]  q4;
  logic        co16, co4;
  logic [15:0] m16 = '0;
  logic [3:0]  m4  = '0;
  int          n_chk  = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  cnt_chain #(.N_SLICES(4), .SLICE_W(4)) u_dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_trk(en_trk), .data_in(din), .count_out(q16), .carry_out(co16)
  );

  cnt_chain #(.N_SLICES(1), .SLICE_W(4)) u_one (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_trk(en_trk), .data_in(din[3:0]), .count_out(q4), .carry_out(co4)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference update from the values present at the edge.
  task automatic cycle();
    @(posedge clk);
    if (!clr_n) begin
      m16 = '0; m4 = '0;
    end else if (!load_n) begin
      m16 = din; m4 = din[3:0];
    end else if (en_par && en_trk) begin
      m16 = m16 + 16'd1; m4 = m4 + 4'd1;
    end
    #1;
  endtask

  task automatic verify(input string req);
    chk(req, q16, m16);
    chk(req, {12'd0, q4}, {12'd0, m4});
    chk({req, "_R8"}, {15'd0, co16}, {15'd0, en_trk && (m16 == 16'hFFFF)});
    chk({req, "_R6"}, {15'd0, co4}, {15'd0, en_trk && (m4 == 4'hF)});
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5EED));
    #1;
    chk("R1 reset", q16, 16'h0000);
    chk("R1 reset", {12'd0, q4}, 16'h0000);
    cycle(); cycle();
    clr_n = 1'b1;

    // R2: load while both enables are low
    load_n = 1'b0; din = 16'h1234; en_par = 1'b0; en_trk = 1'b0;
    cycle(); verify("R2 load enables low");
    // R2: load while both enables are high
    din = 16'h5AC7; en_par = 1'b1; en_trk = 1'b1;
    cycle(); verify("R2 load enables high");

    // R4: hold with one enable low
    load_n = 1'b1; en_par = 1'b0; en_trk = 1'b1;
    cycle(); verify("R4 par low");
    en_par = 1'b1; en_trk = 1'b0;
    cycle(); verify("R4 trk low");

    // R3: counting
    en_trk = 1'b1;
    for (int i = 0; i < 4; i++) begin cycle(); verify("R3 count"); end

    // R7 / R5: carry across the slice boundary; R6 single slice at 15
    load_n = 1'b0; din = 16'h00FE;
    cycle(); verify("R2 preload");
    load_n = 1'b1;
    cycle(); verify("R6 terminal");
    chk("R6 co4 high", {15'd0, co4}, 16'd1);
    cycle(); verify("R7 boundary");
    chk("R7 boundary", q16, 16'h0100);
    chk("R5 wrap", {12'd0, q4}, 16'h0000);

    // R8 / R7: full wrap of the chain
    load_n = 1'b0; din = 16'hFFFE;
    cycle();
    load_n = 1'b1;
    cycle(); verify("R8 terminal");
    chk("R8 carry high", {15'd0, co16}, 16'd1);
    en_trk = 1'b0; #1;
    chk("R6 carry drops", {15'd0, co16}, 16'd0);
    chk("R6 carry drops", {15'd0, co4}, 16'd0);
    cycle(); verify("R4 hold at terminal");
    en_trk = 1'b1;
    cycle(); verify("R7 full wrap");
    chk("R7 full wrap", q16, 16'h0000);

    // R9: enable pulses between edges
    en_par = 1'b0;
    cycle();
    en_par = 1'b1; #1 en_par = 1'b0;
    cycle(); verify("R9 pulse ignored");
    en_par = 1'b1; en_trk = 1'b0; #1 en_trk = 1'b1;
    cycle(); verify("R9 dip ignored");

    // R1: clear between edges
    #0.5 clr_n = 1'b0; #0.5;
    chk("R1 async clear", q16, 16'h0000);
    chk("R1 async clear", {12'd0, q4}, 16'h0000);
    cycle(); verify("R1 held clear");
    clr_n = 1'b1;
    cycle(); verify("R3 after clear");

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      load_n = (($urandom() % 8) != 0);
      en_par = (($urandom() % 4) != 0);
      en_trk = (($urandom() % 4) != 0);
      din    = 16'($urandom());
      if (($urandom() % 8) == 0) din = 16'hFFF0 | 16'($urandom() % 16);
      if (($urandom() % 64) == 0) begin
        clr_n = 1'b0; #1;
        chk("R1 random clear", q16, 16'h0000);
        cycle(); verify("R1 random held");
        clr_n = 1'b1;
      end
      cycle(); verify("R7 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule